// File: doc/BRIEF.md
# Tick-Aligned Run/Stop Up-Counter

This block is an 8-bit up-counter that advances on the falling edges of a slow 256 Hz timebase. Software controls it through a single run bit. A write to that bit does not take effect at once. It is held as a pending request, and the effective run state copies that request only on the next falling edge of the timebase. The count therefore always starts and stops aligned to a timebase edge. Software cannot tell a stop that is still pending from one that has taken effect by reading back the value it wrote. The readback port shows the effective run state instead.

All logic runs on one fast system clock. The slow timebase enters asynchronously. It passes through a synchronizer chain, and a falling-edge detector turns it into a one-cycle pulse. When the run state changes, the count behaves in a fixed way. A start spends its first timebase edge enabling the counter, so the first increment comes on the second edge. A stop lets the counter take exactly one more step, and the readback drops at that same edge. There is no data stream, so every pin is a plain control or status signal with no valid/ready handshake. The write strobe is sampled on every clock, and the block can never stall it.

Top module: `tick_run_counter`

## Requirements
- R1: A synchronous active-high reset sets `count` to 00h, `run_state` to 0 and the pending request to 0. After reset, timebase falling edges leave `count` at 00h until a 1 is written.
- R2: When `run_we` is 1 on a clock edge, `run_wdata` is stored as the pending request. That write does not change `run_state` or `count` before the next timebase falling edge.
- R3: On each detected falling edge of `tick_256`, `run_state` takes the pending request. The resulting change appears at the ports three system clocks after `tick_256` falls: two synchronizer flops plus one output register.
- R4: After a 1 is written while stopped, the first falling edge sets `run_state` to 1 and leaves `count` unchanged. The second falling edge is the first to increment.
- R5: After a 0 is written while running, the next falling edge increments `count` once more and clears `run_state`. `run_state` reads 1 until that edge.
- R6: While `run_state` is 1, each falling edge adds exactly 1 to `count`. Rising edges and steady levels of `tick_256` never change `count`.
- R7: `count` wraps from FFh to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_256 | input | 1 | Asynchronous 256 Hz timebase |
| run_we | input | 1 | Write strobe for the run bit |
| run_wdata | input | 1 | Run bit value to write (1 = run, 0 = stop) |
| run_state | output | 1 | Effective run state (readback) |
| count | output | 8 | Current count value |

## Verification
If the pending request is wrong, the error stays hidden until the next timebase falling edge. It then shows up as a wrong `run_state`, and at the following edge as a missing or extra increment. A wrong effective run flag or a faulty edge detector shows on `count` within three system clocks of the timebase edge. The bench compares every edge against an arithmetic model, so a step that is skipped or doubled is caught on the edge where it happens. A wrap fault shows only on the 256th increment, so the sweep keeps the counter running for more than one full cycle of the count.

// File: rtl/tick_run_pkg.sv
package tick_run_pkg;
  localparam int unsigned CNT_W_DEF   = 8;
  localparam int unsigned SYNC_DEF    = 2;

  function automatic logic [CNT_W_DEF-1:0] step_count(input logic [CNT_W_DEF-1:0] c);
    return c + 1'b1;
  endfunction
endpackage

// File: rtl/tick_fall_detect.sv
module tick_fall_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_async,
  output logic fall_pulse
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], tick_async};
      prev_q  <= chain_q[LAST];
    end
  end

  assign fall_pulse = prev_q & ~chain_q[LAST];

  // R3: an edge pulse lasts exactly one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/run_request_ctrl.sv
module run_request_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_data,
  input  logic edge_fall,
  output logic run_eff
);
  logic pend_q;
  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (wr_en)     pend_q <= wr_data;
      if (edge_fall) run_q  <= pend_q;
    end
  end

  assign run_eff = run_q;

  // R2: a write alone never moves the effective state
  a_r2_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
    !edge_fall |=> $stable(run_eff));
  // R3: the effective state follows the request on an edge
  a_r3_take_request: assert property (@(posedge clk) disable iff (rst)
    edge_fall |=> run_eff == $past(pend_q));
  // R1: reset clears the effective state
  a_r1_reset_run: assert property (@(posedge clk)
    rst |=> !run_eff);
endmodule

// File: rtl/edge_up_counter.sv
module edge_up_counter #(
  parameter int unsigned CNT_W = tick_run_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             enable,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (step && enable) cnt_q <= cnt_q + ONE;
  end

  assign value = cnt_q;

  // R6: the count changes only on an enabled step
  a_r6_stable_no_step: assert property (@(posedge clk) disable iff (rst)
    !(step && enable) |=> $stable(value));
  // R6, R7: an enabled step adds one, modulo the width
  a_r7_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (step && enable) |=> value == CNT_W'($past(value) + ONE));
  // R1: reset clears the count
  a_r1_reset_count: assert property (@(posedge clk)
    rst |=> value == '0);
endmodule

// File: rtl/tick_run_counter.sv
module tick_run_counter #(
  parameter int unsigned CNT_W       = tick_run_pkg::CNT_W_DEF,
  parameter int unsigned SYNC_STAGES = tick_run_pkg::SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_256,
  input  logic             run_we,
  input  logic             run_wdata,
  output logic             run_state,
  output logic [CNT_W-1:0] count
);
  logic fall_w;
  logic run_w;

  tick_fall_detect #(.STAGES(SYNC_STAGES)) u_fall (
    .clk        (clk),
    .rst        (rst),
    .tick_async (tick_256),
    .fall_pulse (fall_w)
  );

  run_request_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (run_we),
    .wr_data   (run_wdata),
    .edge_fall (fall_w),
    .run_eff   (run_w)
  );

  edge_up_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .step   (fall_w),
    .enable (run_w),
    .value  (count)
  );

  assign run_state = run_w;

  // R5: a stop edge still steps the count once
  a_r5_last_step: assert property (@(posedge clk) disable iff (rst)
    (fall_w && run_w) |=> count != $past(count));
  // R4: a start edge does not step the count
  a_r4_start_no_step: assert property (@(posedge clk) disable iff (rst)
    (fall_w && !run_w) |=> $stable(count));
endmodule

// File: tb/tick_run_counter_tb.sv
module tick_run_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       we = 1'b0;
  logic       wd = 1'b0;
  logic       run_rd;
  logic [7:0] cnt;

  int n_vec = 0;
  int n_bad = 0;
  bit m_run = 1'b0;
  bit m_pend = 1'b0;
  logic [7:0] m_cnt = 8'h00;

  always #2 clk = ~clk;

  tick_run_counter dut_i (
    .clk(clk), .rst(rst), .tick_256(tick), .run_we(we),
    .run_wdata(wd), .run_state(run_rd), .count(cnt)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input bit v);
    we = 1'b1; wd = v;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
    m_pend = v;
    chk("R2 run", {7'd0, run_rd}, {7'd0, m_run});
    chk("R2 count", cnt, m_cnt);
  endtask

  task automatic one_fall();
    bit was;
    string tag;
    tick = 1'b1;
    clocks(6);
    chk("R6 rise", cnt, m_cnt);
    tick = 1'b0;
    clocks(2);
    chk("R3 latency", cnt, m_cnt);
    clocks(3);
    was = m_run;
    if (m_run) m_cnt = m_cnt + 8'd1;
    m_run = m_pend;
    if (!was && m_run)      tag = "R4";
    else if (was && !m_run) tag = "R5";
    else if (was && m_cnt == 8'h00) tag = "R7";
    else tag = "R6";
    chk(tag, cnt, m_cnt);
    chk(was && !m_run ? "R5 run" : "R3 run", {7'd0, run_rd}, {7'd0, m_run});
  endtask

  initial begin
    clocks(4);
    rst = 1'b0;
    clocks(1);
    chk("R1 count", cnt, 8'h00);
    chk("R1 run", {7'd0, run_rd}, 8'h00);
    one_fall();
    one_fall();
    chk("R1 idle", cnt, 8'h00);
    for (int i = 0; i < 640; i++) begin
      case (i)
        0, 330, 400, 401, 451, 520: wr(1'b1);
        320, 331, 450, 600:         wr(1'b0);
        default: ;
      endcase
      one_fall();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule